// File: doc/BRIEF.md
# PCI Interrupt Router and Trigger

This block takes interrupt events raised by PCI devices, each identified by the slot the device sits in and the interrupt pin it uses (pins A to D encoded 0 to 3). It folds the pair onto an internal interrupt number with a fixed per-slot swizzle and drives a single CPU interrupt line. Internal numbers start at a base of 32, so internal line `n` is routed number `32 + n`. Two 32-bit configuration words select, per internal line, whether the line behaves as a pulse source and, for level lines, which level the output takes.

Events arrive one per cycle, qualified by a valid strobe. A small state machine holds the output: `TRG_QUIET` (output low), `TRG_HELD` (output held high by a level line) and `TRG_BLIP` (a one-cycle pulse). Transitions: any accepted event on a line whose pulse bit is set enters `TRG_BLIP`; an accepted event on a level line enters `TRG_HELD` when the line's level bit is 1 and `TRG_QUIET` when it is 0; with no accepted event `TRG_BLIP` falls back to `TRG_QUIET` and the other two states stay where they are. The output is registered, so every change shows one clock after the event is sampled.

Events whose slot has no translation keep the raw pin number, which lies below the base; such events are dropped and leave the output untouched.

Top module: `pirq_router`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `cpu_irq` is 0; an asserted reset drops a high output to 0.
- R2: Slot 5 routes pin p to number 32 + (p mod 4), i.e. internal line p.
- R3: Slot 6 routes every pin to internal line 4 and slot 7 routes every pin to internal line 5.
- R4: Slots 8 to 12 route pin p to internal line 6 + (slot - 8) + p.
- R5: Any other slot yields the raw pin number (below 32); such an event changes neither `cpu_irq` nor the held state.
- R6: When bit n of `edge_cfg` is 1, an accepted event on line n makes `cpu_irq` 1 for exactly one cycle and 0 afterwards unless another event is accepted; back-to-back events give one high cycle each.
- R7: When bit n of `edge_cfg` is 0, an accepted event on line n sets `cpu_irq` to bit n of `pol_cfg` and the output keeps that value until the next accepted event, even if `pol_cfg` changes.
- R8: With `evt_valid` low, slot, pin and configuration inputs have no effect on `cpu_irq`.
- R9: `cpu_irq` is registered: it still shows the old value while an event is presented and takes the new value after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event strobe, one event per cycle |
| evt_slot | input | SLOT_W | PCI slot number of the event source |
| evt_pin | input | PIN_W | Interrupt pin, 0 = A to 3 = D |
| edge_cfg | input | LINE_CNT | Per internal line: 1 = pulse source, 0 = level source |
| pol_cfg | input | LINE_CNT | Per internal line: level driven for a level source |
| cpu_irq | output | 1 | Registered CPU interrupt line |

## Verification
The assertions check on every cycle that a pulse-line event raises the output on the next cycle, that a pulse ends after one cycle when no further event comes, that a level-line event leaves the output equal to the line's level bit, and that the output stays stable in the absence of an accepted event. Only the bench's scenarios can show that each slot and pin lands on the right internal line, that untranslated slots are dropped, and that a reset in the middle of activity clears a high output; it does this by steering one-hot level words so that only the expected line can move the output.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic [1:0] {
        TRG_QUIET = 2'b00,
        TRG_HELD  = 2'b01,
        TRG_BLIP  = 2'b10
    } trg_state_e;

    function automatic logic trg_drives_high(input trg_state_e st);
        return (st == TRG_HELD) || (st == TRG_BLIP);
    endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
    parameter int SLOT_W        = 5,
    parameter int PIN_W         = 2,
    parameter int NUM_W         = 7,
    parameter int IRQ_BASE      = 32,
    parameter int LINE_CNT      = 32,
    parameter int SHARED_SLOT   = 5,
    parameter int SOLO_A_SLOT   = 6,
    parameter int SOLO_A_LINE   = 4,
    parameter int SOLO_B_SLOT   = 7,
    parameter int SOLO_B_LINE   = 5,
    parameter int EXP_FIRST     = 8,
    parameter int EXP_LAST      = 12,
    parameter int EXP_LINE_BASE = 6
) (
    input  logic [SLOT_W-1:0]          slot_i,
    input  logic [PIN_W-1:0]           pin_i,
    output logic [NUM_W-1:0]           route_num_o,
    output logic                       internal_o,
    output logic [$clog2(LINE_CNT)-1:0] line_o
);

    localparam int EXP_CNT = EXP_LAST - EXP_FIRST + 1;
    localparam int LINE_W  = $clog2(LINE_CNT);

    logic [EXP_CNT-1:0] exp_hit;
    logic [NUM_W-1:0]   exp_num [EXP_CNT];
    logic [NUM_W-1:0]   pin_ext;
    logic [NUM_W-1:0]   line_full;

    assign pin_ext = NUM_W'(pin_i);

    for (genvar g = 0; g < EXP_CNT; g++) begin : g_exp
        assign exp_hit[g] = (slot_i == SLOT_W'(EXP_FIRST + g));
        assign exp_num[g] = NUM_W'(IRQ_BASE + EXP_LINE_BASE + g) + pin_ext;
    end

    always_comb begin
        route_num_o = pin_ext;
        if (slot_i == SLOT_W'(SHARED_SLOT)) begin
            route_num_o = NUM_W'(IRQ_BASE) + (pin_ext & NUM_W'(3));
        end else if (slot_i == SLOT_W'(SOLO_A_SLOT)) begin
            route_num_o = NUM_W'(IRQ_BASE + SOLO_A_LINE);
        end else if (slot_i == SLOT_W'(SOLO_B_SLOT)) begin
            route_num_o = NUM_W'(IRQ_BASE + SOLO_B_LINE);
        end else begin
            for (int i = 0; i < EXP_CNT; i++) begin
                if (exp_hit[i]) begin
                    route_num_o = exp_num[i];
                end
            end
        end
    end

    assign internal_o = (route_num_o >= NUM_W'(IRQ_BASE)) &&
                        (route_num_o <  NUM_W'(IRQ_BASE + LINE_CNT));
    assign line_full  = route_num_o - NUM_W'(IRQ_BASE);
    assign line_o     = line_full[LINE_W-1:0];

    // R4: an expansion slot always lands inside the line window
    always_comb begin
        if (|exp_hit) begin
            a_r4_exp_in_window: assert (internal_o)
                else $error("expansion slot routed outside the line window");
        end
    end

endmodule

// File: rtl/pirq_line_select.sv
module pirq_line_select #(
    parameter int LINE_CNT = 32
) (
    input  logic [LINE_CNT-1:0]         edge_cfg_i,
    input  logic [LINE_CNT-1:0]         pol_cfg_i,
    input  logic [$clog2(LINE_CNT)-1:0] line_i,
    output logic                        edge_bit_o,
    output logic                        pol_bit_o
);

    logic [LINE_CNT-1:0] line_dec;

    for (genvar g = 0; g < LINE_CNT; g++) begin : g_dec
        assign line_dec[g] = (line_i == $clog2(LINE_CNT)'(g));
    end

    assign edge_bit_o = |(line_dec & edge_cfg_i);
    assign pol_bit_o  = |(line_dec & pol_cfg_i);

endmodule

// File: rtl/pirq_trigger_fsm.sv
module pirq_trigger_fsm
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic edge_bit_i,
    input  logic pol_bit_i,
    output logic irq_o
);

    trg_state_e state_q;
    trg_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (fire_i) begin
            if (edge_bit_i) begin
                state_d = TRG_BLIP;
            end else if (pol_bit_i) begin
                state_d = TRG_HELD;
            end else begin
                state_d = TRG_QUIET;
            end
        end else begin
            unique case (state_q)
                TRG_QUIET: state_d = TRG_QUIET;
                TRG_HELD:  state_d = TRG_HELD;
                TRG_BLIP:  state_d = TRG_QUIET;
                default:   state_d = TRG_QUIET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRG_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= trg_drives_high(state_d);
        end
    end

    // R6: a pulse-line event raises the output on the next cycle
    a_r6_edge_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && edge_bit_i) |=> irq_o);

    // R6: a pulse lasts one cycle when no event follows
    a_r6_blip_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRG_BLIP && !fire_i) |=> !irq_o);

    // R7: a level-line event leaves the output at the level bit
    a_r7_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !edge_bit_i) |=> (irq_o == $past(pol_bit_i)));

    // R8: without an accepted event a non-pulse output is stable
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_i && state_q != TRG_BLIP) |=> $stable(irq_o));

endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
    parameter int SLOT_W   = 5,
    parameter int PIN_W    = 2,
    parameter int LINE_CNT = 32,
    parameter int IRQ_BASE = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [SLOT_W-1:0]   evt_slot,
    input  logic [PIN_W-1:0]    evt_pin,
    input  logic [LINE_CNT-1:0] edge_cfg,
    input  logic [LINE_CNT-1:0] pol_cfg,
    output logic                cpu_irq
);

    localparam int NUM_W  = $clog2(IRQ_BASE + LINE_CNT) + 1;
    localparam int LINE_W = $clog2(LINE_CNT);

    logic [NUM_W-1:0]  route_num;
    logic              route_internal;
    logic [LINE_W-1:0] route_line;
    logic              line_edge;
    logic              line_pol;
    logic              fire;

    pirq_swizzle #(
        .SLOT_W   (SLOT_W),
        .PIN_W    (PIN_W),
        .NUM_W    (NUM_W),
        .IRQ_BASE (IRQ_BASE),
        .LINE_CNT (LINE_CNT)
    ) u_swizzle (
        .slot_i      (evt_slot),
        .pin_i       (evt_pin),
        .route_num_o (route_num),
        .internal_o  (route_internal),
        .line_o      (route_line)
    );

    pirq_line_select #(
        .LINE_CNT (LINE_CNT)
    ) u_line_select (
        .edge_cfg_i (edge_cfg),
        .pol_cfg_i  (pol_cfg),
        .line_i     (route_line),
        .edge_bit_o (line_edge),
        .pol_bit_o  (line_pol)
    );

    assign fire = evt_valid && route_internal;

    pirq_trigger_fsm u_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .edge_bit_i (line_edge),
        .pol_bit_i  (line_pol),
        .irq_o      (cpu_irq)
    );

endmodule

// File: tb/pirq_router_bench.sv
`timescale 1ns/1ps
module pirq_router_bench;

    localparam int LINE_CNT = 32;
    localparam logic [5:0] NONE = 6'h3f;
    localparam int NVEC = 13;
    // {slot[12:8], pin[7:6], expected line[5:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {5'd5,  2'd0, 6'd0},  {5'd5,  2'd3, 6'd3},
        {5'd6,  2'd2, 6'd4},  {5'd7,  2'd1, 6'd5},
        {5'd8,  2'd0, 6'd6},  {5'd9,  2'd2, 6'd9},
        {5'd10, 2'd1, 6'd9},  {5'd11, 2'd3, 6'd12},
        {5'd12, 2'd3, 6'd13}, {5'd0,  2'd1, NONE},
        {5'd4,  2'd2, NONE},  {5'd13, 2'd0, NONE},
        {5'd31, 2'd3, NONE}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                evt_valid = 1'b0;
    logic [4:0]          evt_slot = '0;
    logic [1:0]          evt_pin = '0;
    logic [LINE_CNT-1:0] edge_cfg = '0;
    logic [LINE_CNT-1:0] pol_cfg = '0;
    logic                cpu_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pirq_router u_pirq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_slot  (evt_slot),
        .evt_pin   (evt_pin),
        .edge_cfg  (edge_cfg),
        .pol_cfg   (pol_cfg),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: cpu_irq=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic send(input logic [4:0] s, input logic [1:0] p);
        @(negedge clk);
        evt_slot  = s;
        evt_pin   = p;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    function automatic string route_req(input logic [4:0] s);
        if (s == 5'd5) return "R2";
        if (s == 5'd6 || s == 5'd7) return "R3";
        return "R4";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cpu_irq=%0b expected completion", cpu_irq);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 in reset", cpu_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", cpu_irq, 1'b0);

        // Routing table (R2, R3, R4, R5)
        for (int i = 0; i < NVEC; i++) begin
            logic [4:0] s;
            logic [1:0] p;
            logic [5:0] l;
            s = VEC[i][12:8];
            p = VEC[i][7:6];
            l = VEC[i][5:0];
            if (l != NONE) begin
                edge_cfg = '0;
                pol_cfg  = LINE_CNT'(1) << l;
                send(s, p);
                check(route_req(s), cpu_irq, 1'b1);
                pol_cfg = ~(LINE_CNT'(1) << l);
                send(s, p);
                check(route_req(s), cpu_irq, 1'b0);
            end else begin
                edge_cfg = '0;
                pol_cfg  = '1;
                send(5'd6, 2'd0);
                check("R7 setup high", cpu_irq, 1'b1);
                pol_cfg  = '0;
                edge_cfg = '1;
                send(s, p);
                check("R5 untranslated slot ignored", cpu_irq, 1'b1);
                @(negedge clk);
                check("R5 no pulse afterwards", cpu_irq, 1'b1);
            end
        end

        // R7: level held while pol_cfg changes without events
        edge_cfg = '0;
        pol_cfg  = '1;
        send(5'd5, 2'd1);
        pol_cfg = '0;
        repeat (3) @(negedge clk);
        check("R7 level held", cpu_irq, 1'b1);
        send(5'd5, 2'd1);
        check("R7 level low", cpu_irq, 1'b0);

        // R8: routed slot presented without valid
        pol_cfg  = '1;
        evt_slot = 5'd6;
        evt_pin  = 2'd0;
        repeat (4) @(negedge clk);
        check("R8 valid low ignored", cpu_irq, 1'b0);

        // R9: registered output
        @(negedge clk);
        evt_slot  = 5'd6;
        evt_valid = 1'b1;
        #1;
        check("R9 old value before edge", cpu_irq, 1'b0);
        @(posedge clk);
        #1;
        check("R9 new value after edge", cpu_irq, 1'b1);
        @(negedge clk);
        evt_valid = 1'b0;
        pol_cfg   = '0;
        send(5'd6, 2'd0);

        // R6: single pulse on line 5 (slot 7)
        edge_cfg = LINE_CNT'(1) << 5;
        send(5'd7, 2'd2);
        check("R6 pulse high", cpu_irq, 1'b1);
        @(negedge clk);
        check("R6 pulse ends", cpu_irq, 1'b0);
        @(negedge clk);
        check("R6 stays low", cpu_irq, 1'b0);

        // R6: back-to-back events
        @(negedge clk);
        evt_slot  = 5'd7;
        evt_valid = 1'b1;
        @(negedge clk);
        check("R6 back-to-back first", cpu_irq, 1'b1);
        @(negedge clk);
        evt_valid = 1'b0;
        check("R6 back-to-back second", cpu_irq, 1'b1);
        @(negedge clk);
        check("R6 back-to-back end", cpu_irq, 1'b0);

        // R6: pulse from held-high state falls to low
        edge_cfg = '0;
        pol_cfg  = '1;
        send(5'd5, 2'd2);
        check("R7 held before pulse", cpu_irq, 1'b1);
        edge_cfg = '1;
        send(5'd5, 2'd2);
        check("R6 pulse over held", cpu_irq, 1'b1);
        @(negedge clk);
        check("R6 low after pulse over held", cpu_irq, 1'b0);

        // R1: reset in the middle of activity
        edge_cfg = '0;
        send(5'd8, 2'd1);
        check("R7 high before reset", cpu_irq, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears output", cpu_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 low after release", cpu_irq, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule